// File: doc/BRIEF.md
# CB-Group Bit Manipulation Unit

This unit carries out the byte shifts, rotates, nibble exchange and single-bit test, clear and set operations of a small 8-bit processor core. It also runs the four one-byte accumulator rotates that need no prefix. The core's sequencer supplies three things with a one-cycle request: the opcode byte, a flag that tells whether the byte came after the prefix, and the register file and flag byte at that moment. The unit latches these inputs. After the machine-cycle count of the instruction has elapsed, it returns the new value, the destination code, a register write-enable and the new Z, N, H and C flags, and marks that moment with a one-cycle done pulse.

The operand can be the memory byte whose address is held in the H:L register pair. In that case the unit performs the read-modify-write itself on a simple synchronous memory port: a read strobe, the byte back one cycle later, then a write strobe to the same address. The timing matches the instruction's cycle budget. While it is busy, further requests are ignored.

Top module: `bitop_unit`

## Requirements
- R1: In a prefixed opcode, bits 2:0 select the operand: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 the memory byte at address {H,L}, 7 A. `regs` carries register code i in bits [8i+7:8i]. For a register operand, `res_dst` reports that code. For an accumulator rotate, it reports 7.
- R2: In a prefixed opcode with bits 7:6 = 00, bits 5:3 pick the operation. 0 rotates left circularly and 1 rotates right circularly. 2 rotates left through carry and 3 rotates right through carry. 4 shifts left with a 0 in. 5 shifts right keeping bit 7. 6 swaps the nibbles. 7 shifts right with a 0 in.
- R3: For prefixed group-00 operations, Z is set from a zero result and N and H are cleared. C takes the bit shifted or rotated out, and the nibble swap clears C. `flags_out` is {Z,N,H,C} in bits 3..0.
- R4: The unprefixed opcodes 0x07, 0x0F, 0x17 and 0x1F rotate A in the same way as prefixed operations 0 to 3. They always clear Z, N and H, even when the result is zero, and load C with the outgoing bit.
- R5: Bit test (bits 7:6 = 01, bit index in bits 5:3) sets Z when the chosen bit is 0, clears N, sets H and keeps C. It writes nothing back: `res_we` is 0 and no memory write occurs.
- R6: Bit clear (10) and bit set (11) change only the chosen bit and return `flags_in` unchanged.
- R7: An instruction takes 1 machine cycle for an accumulator rotate, 2 for a prefixed register operand and 4 for a memory operand, where one machine cycle is 4 clocks. `done` is a one-cycle pulse 4×M clocks after the accepting edge, and `mcycles` then reads M.
- R8: For a memory operand, `mem_rd` pulses for one cycle 8 clocks after acceptance, with `mem_addr` = {H,L}. If the operation writes back, `mem_wr` pulses 12 clocks after acceptance at the same address, with the result on `mem_wdata`. `res_we` stays 0.
- R9: A request made while `busy` is high is ignored and does not change the running instruction's outcome.
- R10: An unprefixed opcode other than the four accumulator rotates is not accepted: `busy` stays low and no done pulse follows.
- R11: After reset, `busy`, `done`, `mem_rd` and `mem_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start request, accepted when idle |
| prefixed | input | 1 | Opcode byte followed the prefix |
| opcode | input | 8 | Opcode byte |
| regs | input | 64 | Register file, code i in bits [8i+7:8i] |
| flags_in | input | 4 | Current {Z,N,H,C} |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 8 | New operand value |
| res_we | output | 1 | Write `result` to register `res_dst` |
| res_dst | output | 3 | Destination register code |
| flags_out | output | 4 | New {Z,N,H,C} |
| mcycles | output | 3 | Machine cycles the instruction took |
| mem_addr | output | 16 | Memory address {H,L} |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |

## Verification
The directed cases cover several known pitfalls. A shift right that zero-fills in place of sign-fill would return 0x40 for 0x80. A fast rotate whose result is zero would leave Z set if it shared the prefixed flag rule. A through-carry rotate that ignored the incoming carry would lose the top bit. A bit test on memory that wrote back would produce a spurious write strobe. Random vectors across all groups, operands and flag states compare the result, flags, destination, done cycle and memory strobe cycles against a bench model. Further checks poke a request while the unit is busy and offer an unsupported unprefixed opcode. A design that accepted either would show a second done pulse or a changed result.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_t;

  typedef enum logic [2:0] {
    SH_ROLC = 3'd0,
    SH_RORC = 3'd1,
    SH_ROL  = 3'd2,
    SH_ROR  = 3'd3,
    SH_SHL  = 3'd4,
    SH_ASR  = 3'd5,
    SH_NSWP = 3'd6,
    SH_LSR  = 3'd7
  } shop_t;

  localparam logic [2:0] SEL_MEM = 3'd6;
  localparam logic [2:0] SEL_ACC = 3'd7;
  localparam int         IDX_HI  = 4;
  localparam int         IDX_LO  = 5;

  typedef struct packed {
    logic       valid;
    logic       fast;
    grp_t       grp;
    shop_t      sop;
    logic [2:0] bidx;
    logic [2:0] sel;
    logic       use_mem;
    logic       wb_mem;
    logic       wb_reg;
    logic [2:0] mcyc;
  } dec_t;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic       prefixed,
  input  logic [7:0] op,
  output dec_t       dec
);

  logic writes;

  always_comb begin
    dec    = '0;
    writes = 1'b0;
    if (prefixed) begin
      dec.valid   = 1'b1;
      dec.grp     = grp_t'(op[7:6]);
      dec.sop     = shop_t'(op[5:3]);
      dec.bidx    = op[5:3];
      dec.sel     = op[2:0];
      dec.use_mem = (op[2:0] == SEL_MEM);
      writes      = (op[7:6] != 2'b01);
      dec.wb_mem  = dec.use_mem && writes;
      dec.wb_reg  = !dec.use_mem && writes;
      dec.mcyc    = dec.use_mem ? 3'd4 : 3'd2;
    end else if (op[7:5] == 3'b000 && op[2:0] == 3'b111) begin
      dec.valid  = 1'b1;
      dec.fast   = 1'b1;
      dec.grp    = GRP_SHIFT;
      dec.sop    = shop_t'({1'b0, op[4:3]});
      dec.sel    = SEL_ACC;
      dec.wb_reg = 1'b1;
      dec.mcyc   = 3'd1;
    end
  end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DW = 8
) (
  input  dec_t          dec,
  input  logic [DW-1:0] v,
  input  flags_t        fin,
  output logic [DW-1:0] res,
  output flags_t        fout
);

  localparam int HALF = DW / 2;
  localparam int BW   = $clog2(DW);

  logic [DW-1:0] sh_res;
  logic          sh_out;
  logic [DW-1:0] bmask;

  always_comb begin
    sh_res = v;
    sh_out = 1'b0;
    unique case (dec.sop)
      SH_ROLC: begin sh_res = {v[DW-2:0], v[DW-1]}; sh_out = v[DW-1]; end
      SH_RORC: begin sh_res = {v[0], v[DW-1:1]};    sh_out = v[0];    end
      SH_ROL:  begin sh_res = {v[DW-2:0], fin.c};   sh_out = v[DW-1]; end
      SH_ROR:  begin sh_res = {fin.c, v[DW-1:1]};   sh_out = v[0];    end
      SH_SHL:  begin sh_res = {v[DW-2:0], 1'b0};    sh_out = v[DW-1]; end
      SH_ASR:  begin sh_res = {v[DW-1], v[DW-1:1]}; sh_out = v[0];    end
      SH_NSWP: begin sh_res = {v[HALF-1:0], v[DW-1:HALF]}; sh_out = 1'b0; end
      SH_LSR:  begin sh_res = {1'b0, v[DW-1:1]};    sh_out = v[0];    end
      default: begin sh_res = v; sh_out = 1'b0; end
    endcase
  end

  assign bmask = DW'(1) << dec.bidx[BW-1:0];

  always_comb begin
    res  = v;
    fout = fin;
    unique case (dec.grp)
      GRP_SHIFT: begin
        res    = sh_res;
        fout.z = dec.fast ? 1'b0 : (sh_res == '0);
        fout.n = 1'b0;
        fout.h = 1'b0;
        fout.c = sh_out;
      end
      GRP_TEST: begin
        res    = v;
        fout.z = ((v & bmask) == '0);
        fout.n = 1'b0;
        fout.h = 1'b1;
        fout.c = fin.c;
      end
      GRP_CLR: res = v & ~bmask;
      GRP_SET: res = v | bmask;
      default: res = v;
    endcase
  end

endmodule

// File: rtl/bitop_seq.sv
module bitop_seq #(
  parameter int TPM = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] mcyc,
  input  logic       use_mem,
  input  logic       wb_mem,
  output logic       busy,
  output logic       last,
  output logic       rd_next,
  output logic       cap,
  output logic       wr_next
);

  localparam int            MAXT = 4 * TPM;
  localparam int            CW   = $clog2(MAXT + 1) + 1;
  localparam logic [CW-1:0] RD_T = CW'(2 * TPM);
  localparam logic [CW-1:0] WR_T = CW'(3 * TPM);

  logic [CW-1:0] t_q;
  logic [CW-1:0] total_q;
  logic          mem_q;
  logic          wbm_q;
  logic [CW-1:0] t_inc;

  assign t_inc = t_q + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      t_q     <= '0;
      total_q <= '0;
      mem_q   <= 1'b0;
      wbm_q   <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      t_q     <= '0;
      total_q <= CW'(int'(mcyc) * TPM);
      mem_q   <= use_mem;
      wbm_q   <= wb_mem;
    end else if (busy) begin
      t_q <= t_inc;
      if (last) busy <= 1'b0;
    end
  end

  assign last    = busy && (t_inc == total_q);
  assign rd_next = busy && mem_q && (t_inc == RD_T);
  assign cap     = busy && mem_q && (t_q == RD_T + CW'(1));
  assign wr_next = busy && wbm_q && (t_inc == WR_T);

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREGS = 8,
  parameter int TPM   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              prefixed,
  input  logic [7:0]        opcode,
  input  logic [NREGS*DW-1:0] regs,
  input  logic [3:0]        flags_in,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     result,
  output logic              res_we,
  output logic [2:0]        res_dst,
  output logic [3:0]        flags_out,
  output logic [2:0]        mcycles,
  output logic [2*DW-1:0]   mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DW-1:0]     mem_wdata
);

  localparam int AW = 2 * DW;

  logic [DW-1:0] rf [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_unpack
    assign rf[g] = regs[g*DW +: DW];
  end

  dec_t          dec_d, dec_q;
  logic [DW-1:0] opnd_q;
  flags_t        flg_q;
  logic [DW-1:0] alu_res;
  flags_t        alu_flg;
  logic          accept, last, rd_next, cap, wr_next;
  logic [AW-1:0] hl_addr;

  bitop_decode u_dec (
    .prefixed (prefixed),
    .op       (opcode),
    .dec      (dec_d)
  );

  assign accept  = req && !busy && dec_d.valid;
  assign hl_addr = {rf[IDX_HI], rf[IDX_LO]};

  bitop_seq #(.TPM(TPM)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .mcyc    (dec_d.mcyc),
    .use_mem (dec_d.use_mem),
    .wb_mem  (dec_d.wb_mem),
    .busy    (busy),
    .last    (last),
    .rd_next (rd_next),
    .cap     (cap),
    .wr_next (wr_next)
  );

  bitop_alu #(.DW(DW)) u_alu (
    .dec  (dec_q),
    .v    (opnd_q),
    .fin  (flg_q),
    .res  (alu_res),
    .fout (alu_flg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q    <= '0;
      opnd_q   <= '0;
      flg_q    <= '0;
      mem_addr <= '0;
    end else if (accept) begin
      dec_q    <= dec_d;
      opnd_q   <= rf[dec_d.sel];
      flg_q    <= flags_t'(flags_in);
      mem_addr <= hl_addr;
    end else if (cap) begin
      opnd_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_wdata <= '0;
      result    <= '0;
      res_we    <= 1'b0;
      res_dst   <= '0;
      flags_out <= '0;
      mcycles   <= '0;
    end else begin
      done   <= last;
      mem_rd <= rd_next;
      mem_wr <= wr_next;
      if (wr_next) mem_wdata <= alu_res;
      if (last) begin
        result    <= alu_res;
        flags_out <= alu_flg;
        res_we    <= dec_q.wb_reg;
        res_dst   <= dec_q.sel;
        mcycles   <= dec_q.mcyc;
      end
    end
  end

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [2*DW-1:0] mem_addr
);

  logic rd_seen;

  always_ff @(posedge clk) begin
    if (rst)         rd_seen <= 1'b0;
    else if (done)   rd_seen <= 1'b0;
    else if (mem_rd) rd_seen <= 1'b1;
  end

  // R11
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !mem_rd && !mem_wr));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R8
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (busy && rd_seen));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mem_addr));

endmodule

bind bitop_unit bitop_unit_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .mem_addr (mem_addr)
);

// File: tb/test_bitop_unit.sv
`timescale 1ns/1ps
module test_bitop_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        prefixed = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] regs = '0;
  logic [3:0]  flags_in = '0;
  logic [7:0]  mem_rdata = '0;
  logic        busy, done, res_we, mem_rd, mem_wr;
  logic [7:0]  result, mem_wdata;
  logic [2:0]  res_dst, mcycles;
  logic [3:0]  flags_out;
  logic [15:0] mem_addr;

  logic [7:0]  mem [256];
  int          nvec = 0;
  int          nfail = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  bitop_unit i_bitop_unit (
    .clk(clk), .rst(rst), .req(req), .prefixed(prefixed), .opcode(opcode),
    .regs(regs), .flags_in(flags_in), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .result(result), .res_we(res_we),
    .res_dst(res_dst), .flags_out(flags_out), .mcycles(mcycles),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  // model: returns {result, Z, N, H, C}
  function automatic logic [11:0] model(input logic pfx, input logic [7:0] op,
                                        input logic [7:0] v, input logic [3:0] f);
    logic [7:0] r;
    logic       c;
    logic [2:0] k;
    logic [1:0] grp;
    logic [3:0] fo;
    grp = pfx ? op[7:6] : 2'b00;
    k   = pfx ? op[5:3] : {1'b0, op[4:3]};
    fo  = f;
    r   = v;
    if (grp == 2'b00) begin
      case (k)
        3'd0: begin c = v[7]; r = (v << 1) | {7'd0, v[7]}; end
        3'd1: begin c = v[0]; r = (v >> 1) | {v[0], 7'd0}; end
        3'd2: begin c = v[7]; r = (v << 1) | {7'd0, f[0]}; end
        3'd3: begin c = v[0]; r = (v >> 1) | {f[0], 7'd0}; end
        3'd4: begin c = v[7]; r = v << 1; end
        3'd5: begin c = v[0]; r = (v >> 1) | (v & 8'h80); end
        3'd6: begin c = 1'b0; r = {v[3:0], v[7:4]}; end
        default: begin c = v[0]; r = v >> 1; end
      endcase
      fo = {pfx ? (r == 8'd0) : 1'b0, 1'b0, 1'b0, c};
    end else if (grp == 2'b01) begin
      fo = {~v[op[5:3]], 1'b0, 1'b1, f[0]};
    end else if (grp == 2'b10) begin
      r = v & ~(8'd1 << op[5:3]);
    end else begin
      r = v | (8'd1 << op[5:3]);
    end
    return {r, fo};
  endfunction

  task automatic apply(input logic pfx, input logic [7:0] op, input logic [63:0] rf,
                       input logic [3:0] fl, input bit poke);
    logic [2:0]  sel;
    logic [15:0] hl;
    bit          is_mem, is_test;
    logic [7:0]  v, er;
    logic [3:0]  ef;
    int          ecyc, tt, done_j, rd_j, wr_j;
    logic [15:0] rd_a, wr_a;
    logic [7:0]  wr_d;
    string       rtag, ftag;
    sel     = pfx ? op[2:0] : 3'd7;
    hl      = {rf[39:32], rf[47:40]};
    is_mem  = pfx && (sel == 3'd6);
    is_test = pfx && (op[7:6] == 2'b01);
    v       = is_mem ? mem[hl[7:0]] : rf[8*sel +: 8];
    {er, ef} = model(pfx, op, v, fl);
    ecyc    = !pfx ? 1 : (is_mem ? 4 : 2);
    tt      = ecyc * 4;
    if (!pfx)                      begin rtag = "R4 result"; ftag = "R4 flags"; end
    else if (op[7:6] == 2'b00)     begin rtag = "R2 result"; ftag = "R3 flags"; end
    else if (op[7:6] == 2'b01)     begin rtag = "R5 result"; ftag = "R5 flags"; end
    else                           begin rtag = "R6 result"; ftag = "R6 flags"; end
    @(negedge clk);
    req = 1'b1; prefixed = pfx; opcode = op; regs = rf; flags_in = fl;
    @(negedge clk);
    req = 1'b0; regs = {$urandom, $urandom}; flags_in = 4'($urandom);
    done_j = 99; rd_j = 99; wr_j = 99; rd_a = '0; wr_a = '0; wr_d = '0;
    for (int j = 0; j < 40; j++) begin
      if (done) begin done_j = j; break; end
      if (mem_rd) begin rd_j = j; rd_a = mem_addr; end
      if (mem_wr) begin wr_j = j; wr_a = mem_addr; wr_d = mem_wdata; end
      if (poke && j == 2) begin req = 1'b1; prefixed = 1'b1; opcode = 8'hFF; end
      if (poke && j == 3) req = 1'b0;
      @(negedge clk);
    end
    chk(done_j == tt, "R7 done cycle", done_j, tt);
    chk(mcycles == 3'(ecyc), "R7 mcycles", mcycles, ecyc);
    chk(result == er, poke ? "R9 result" : rtag, result, er);
    chk(flags_out == ef, ftag, flags_out, ef);
    chk(res_we == (!is_mem && !is_test), "R5 res_we", res_we, !is_mem && !is_test);
    if (!is_mem) chk(res_dst == sel, "R1 res_dst", res_dst, sel);
    if (is_mem) begin
      chk(rd_j == 8 && rd_a == hl, "R8 read slot/addr", {rd_j[15:0], rd_a}, {16'd8, hl});
      if (is_test) chk(wr_j == 99, "R5 no write", wr_j, 99);
      else chk(wr_j == 12 && wr_a == hl && wr_d == er, "R8 write",
               {wr_j[7:0], wr_a, wr_d}, {8'd12, hl, er});
    end else begin
      chk(rd_j == 99 && wr_j == 99, "R1 no memory access", {rd_j, wr_j}, {99, 99});
    end
    for (int j = 0; j < (poke ? 12 : 1); j++) begin
      @(negedge clk);
      chk(!done && !busy, poke ? "R9 no second run" : "R7 done pulse", {done, busy}, 0);
    end
  endtask

  function automatic logic [63:0] mkregs(input logic [7:0] b, input logic [7:0] c,
                                         input logic [7:0] h, input logic [7:0] l,
                                         input logic [7:0] a);
    return {a, 8'h00, l, h, 8'h5A, 8'hA5, c, b};
  endfunction

  initial begin
    #(200000 * 5.0);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !mem_rd && !mem_wr, "R11 reset", {busy, done, mem_rd, mem_wr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done, "R11 after release", {busy, done}, 0);

    // directed corner cases
    apply(1'b1, 8'h28, mkregs(8'h80, 8'h00, 8'h00, 8'h10, 8'h00), 4'h0, 1'b0); // R2 SRA 0x80
    apply(1'b1, 8'h39, mkregs(8'h00, 8'h01, 8'h00, 8'h10, 8'h00), 4'h0, 1'b0); // R3 SRL to zero
    apply(1'b1, 8'h37, mkregs(8'h00, 8'h00, 8'h00, 8'h10, 8'hF0), 4'h1, 1'b0); // R3 swap clears C
    apply(1'b1, 8'h10, mkregs(8'h80, 8'h00, 8'h00, 8'h10, 8'h00), 4'h1, 1'b0); // R2 RL carry in
    apply(1'b1, 8'h18, mkregs(8'h01, 8'h00, 8'h00, 8'h10, 8'h00), 4'h0, 1'b0); // R3 RR to zero
    apply(1'b0, 8'h17, mkregs(8'h00, 8'h00, 8'h00, 8'h10, 8'h80), 4'h8, 1'b0); // R4 zero, Z clear
    apply(1'b0, 8'h0F, mkregs(8'h00, 8'h00, 8'h00, 8'h10, 8'h01), 4'h0, 1'b0); // R4 RRCA
    apply(1'b1, 8'h7F, mkregs(8'h00, 8'h00, 8'h00, 8'h10, 8'h7F), 4'h1, 1'b0); // R5 bit 7 clear
    apply(1'b1, 8'h46, mkregs(8'h00, 8'h00, 8'h00, 8'h20, 8'h00), 4'h0, 1'b0); // R5 test on memory
    apply(1'b1, 8'hBE, mkregs(8'h00, 8'h00, 8'h00, 8'h30, 8'h00), 4'hA, 1'b0); // R6 clear on memory
    apply(1'b1, 8'hC4, mkregs(8'h00, 8'h00, 8'h00, 8'h30, 8'h00), 4'h5, 1'b0); // R6 set on H
    apply(1'b1, 8'h26, mkregs(8'h00, 8'h00, 8'h01, 8'h40, 8'h00), 4'h0, 1'b0); // R8 shift on memory
    apply(1'b1, 8'h00, mkregs(8'h81, 8'h00, 8'h00, 8'h10, 8'h00), 4'h0, 1'b1); // R9 poke while busy

    // R10 unsupported unprefixed opcodes
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      req = 1'b1; prefixed = 1'b0;
      opcode = (k == 0) ? 8'h00 : ((k == 1) ? 8'h27 : 8'h3E);
      @(negedge clk);
      req = 1'b0;
      for (int j = 0; j < 6; j++) begin
        chk(!busy && !done && !mem_rd, "R10 not accepted", {busy, done, mem_rd}, 0);
        @(negedge clk);
      end
    end

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic       pfx;
      logic [7:0] op;
      pfx = ($urandom % 8) != 0;
      if (pfx) op = 8'($urandom);
      else     op = {3'b000, 2'($urandom), 3'b111};
      apply(pfx, op, {$urandom, $urandom}, 4'($urandom), ($urandom % 16) == 0);
    end
    summary();
  end

endmodule